// File: doc/BRIEF.md
# Register Read Request Handler

This block serves a management request that reads a run of consecutive 32-bit registers. The request arrives as a frame of dwords on a simple valid/ready word interface. The first dword is a header whose content is not used here. The second dword is the start address. The third dword is the number of dwords to read. When the last word of the frame has been taken, the block first checks the frame length. Only then does it check the address alignment and the dword count. If all checks pass, it reads the registers one after another through a request/acknowledge register port.

Each returned dword is placed into a flat byte array, least significant byte first. Dword k of the run fills bytes 4k to 4k+3. When the run is finished, or when a check fails, the block raises a one-cycle done pulse. With that pulse it presents a function result code, the number of dwords packed and the byte array. The transport that carries the frames and the register map behind the read port are outside this block.

Top module: `rrq_handler`

## Requirements
- R1: After reset, req_ready is 1, done is 0, rd_req is 0, result is 0x00, rsp_dwords is 0 and rsp_data is all zero.
- R2: A frame whose length is not exactly 3 dwords (word order: header, start address, dword count) ends with result 0x03, and no register read is issued for it.
- R3: A 3-dword frame whose start address has bits [1:0] not equal to zero ends with result 0x04, and no register read is issued for it.
- R4: A 3-dword frame with an aligned address whose dword count (the full 32-bit third word) is 0 or greater than MAX_DW ends with result 0x05, and no register read is issued for it.
- R5: The checks have a fixed priority: length first, then alignment, then count. Only the code of the first failing check is reported.
- R6: Reads are issued one at a time. The first read uses the start address, and each acknowledged read moves the address up by 4 (wrapping at ADDR_W bits). rd_addr is dword aligned and holds steady while a read waits for rd_ack.
- R7: Byte 4k+j of rsp_data (bits [8(4k+j)+7 : 8(4k+j)]) holds bits [8j+7:8j] of the dword read from start address + 4k. So byte 0 is bits [7:0] and byte 3 is bits [31:24] of the first dword.
- R8: Byte slots beyond the dwords read in the current request are zero. A failed request reports rsp_dwords 0 and an all-zero array.
- R9: A request that passes all checks ends with result 0x00, rsp_dwords equal to the requested count, and exactly as many acknowledged reads. done is high for exactly one cycle per frame.
- R10: req_ready is 0 from the cycle after the last frame word is accepted until done has been shown. Words offered during that time are ignored and start no new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Frame word valid |
| req_word | input | 32 | Frame word |
| req_last | input | 1 | Marks the final word of a frame |
| req_ready | output | 1 | Block accepts a frame word |
| rd_req | output | 1 | Register read request, held until acknowledged |
| rd_addr | output | ADDR_W | Byte address of the register being read |
| rd_ack | input | 1 | Read accepted, rd_data valid this cycle |
| rd_data | input | 32 | Register read data |
| done | output | 1 | One-cycle pulse marking the end of a request |
| result | output | 8 | Function result code, valid with done |
| rsp_dwords | output | CNT_W | Number of dwords packed |
| rsp_data | output | 32*MAX_DW | Packed byte array, byte n at bits [8n+7:8n] |

## Verification
The bound checker watches the read port and the completion on every cycle. It checks that reads are aligned, that a waiting read holds its address, and that the address steps by 4 after each acknowledge. It also checks that no read occurs in a request that ends with an error code, that the acknowledge count matches rsp_dwords on success, that done is a single pulse, and that req_ready stays low while the block is busy.

Some behaviours can only be shown by the bench scenarios. These are the exact code chosen when several checks fail at once, the byte placement against known register contents, the zeroing of unused slots after a long request, address wrap-around, and frames of the wrong length in both directions.

// File: rtl/rrq_pkg.sv
// Package: shared result codes, sequencer states and the captured frame
// record used by the register read request handler.
package rrq_pkg;

    localparam int WORD_W       = 32;
    localparam int FRAME_DWORDS = 3;

    localparam logic [7:0] RES_OK        = 8'h00;
    localparam logic [7:0] RES_BAD_LEN   = 8'h03;
    localparam logic [7:0] RES_UNALIGNED = 8'h04;
    localparam logic [7:0] RES_BAD_COUNT = 8'h05;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_READ,
        SEQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic              len_ok;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] count;
    } frame_t;

endpackage

// File: rtl/rrq_frame_rx.sv
// Frame collector: counts the words of an incoming request frame and keeps
// the start address (word 1) and the dword count (word 2). On the last word
// it presents the captured frame for one cycle, flagged with whether its
// length was exactly FRAME_DWORDS.
// Assumes: words are taken only while in_ready is high; the header word is
// not interpreted; the word counter saturates, so long frames stay invalid.
module rrq_frame_rx
    import rrq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_last,
    input  logic              in_ready,
    output logic              frm_vld,
    output frame_t            frm
);

    localparam int LEN_W = 3;
    localparam logic [LEN_W-1:0] LEN_MAX  = '1;
    localparam logic [LEN_W-1:0] LEN_LAST = LEN_W'(FRAME_DWORDS - 1);

    logic [LEN_W-1:0] wcnt_q;
    logic             take;

    assign take = in_valid && in_ready;

    // Purpose: track word position and capture the address and count fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wcnt_q  <= '0;
            frm_vld <= 1'b0;
            frm     <= '0;
        end else begin
            frm_vld <= 1'b0;
            if (take) begin
                if (wcnt_q == 3'd1) begin
                    frm.addr <= in_word;
                end
                if (wcnt_q == 3'd2) begin
                    frm.count <= in_word;
                end
                if (in_last) begin
                    wcnt_q     <= '0;
                    frm_vld    <= 1'b1;
                    frm.len_ok <= (wcnt_q == LEN_LAST);
                end else if (wcnt_q != LEN_MAX) begin
                    wcnt_q <= wcnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/rrq_vet.sv
// Request vetting: purely combinational checks on a captured frame, in the
// fixed order length, alignment, count. Gives the first failing code, or
// RES_OK with go set when the read run may start.
// Assumes: the frame fields are stable while frm_vld is high.
module rrq_vet
    import rrq_pkg::*;
#(
    parameter int MAX_DW = 8
) (
    input  frame_t      frm,
    output logic [7:0]  code,
    output logic        go
);

    localparam logic [WORD_W-1:0] COUNT_LIMIT = WORD_W'(MAX_DW);

    // Purpose: apply the checks in priority order.
    always_comb begin
        go = 1'b0;
        if (!frm.len_ok) begin
            code = RES_BAD_LEN;
        end else if (frm.addr[1:0] != 2'b00) begin
            code = RES_UNALIGNED;
        end else if ((frm.count == '0) || (frm.count > COUNT_LIMIT)) begin
            code = RES_BAD_COUNT;
        end else begin
            code = RES_OK;
            go   = 1'b1;
        end
    end

endmodule

// File: rtl/rrq_seq.sv
// Read sequencer: on a vetted frame it either finishes at once with the
// error code or walks the register port one read at a time. It advances the
// address by 4 on each acknowledge and tells the packer which slot to fill.
// Assumes: rd_ack is only meaningful while rd_req is high; the count given
// with go is between 1 and MAX_DW.
module rrq_seq
    import rrq_pkg::*;
#(
    parameter int MAX_DW = 8,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(MAX_DW + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frm_vld,
    input  frame_t            frm,
    input  logic [7:0]        vet_code,
    input  logic              vet_go,
    input  logic              rd_ack,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              idle,
    output logic              start,
    output logic              slot_we,
    output logic [CNT_W-1:0]  slot_idx,
    output logic              done,
    output logic [7:0]        result
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  total_q;
    logic [7:0]        result_q;
    logic              last_ack;

    assign idle     = (state_q == SEQ_IDLE);
    assign start    = idle && frm_vld;
    assign rd_req   = (state_q == SEQ_READ);
    assign rd_addr  = addr_q;
    assign slot_we  = rd_req && rd_ack;
    assign slot_idx = idx_q;
    assign done     = (state_q == SEQ_DONE);
    assign result   = result_q;
    assign last_ack = slot_we && ((idx_q + CNT_W'(1)) == total_q);

    // Purpose: state, address, slot index and result code of the run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SEQ_IDLE;
            addr_q   <= '0;
            idx_q    <= '0;
            total_q  <= '0;
            result_q <= RES_OK;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (frm_vld) begin
                        result_q <= vet_code;
                        idx_q    <= '0;
                        if (vet_go) begin
                            addr_q  <= frm.addr[ADDR_W-1:0];
                            total_q <= frm.count[CNT_W-1:0];
                            state_q <= SEQ_READ;
                        end else begin
                            state_q <= SEQ_DONE;
                        end
                    end
                end
                SEQ_READ: begin
                    if (slot_we) begin
                        addr_q <= addr_q + STEP;
                        idx_q  <= idx_q + CNT_W'(1);
                        if (last_ack) begin
                            state_q <= SEQ_DONE;
                        end
                    end
                end
                SEQ_DONE: begin
                    state_q <= SEQ_IDLE;
                end
                default: begin
                    state_q <= SEQ_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/rrq_pack.sv
// Byte packer: holds MAX_DW dword slots as a flat byte array, least
// significant byte first. The slot named by the sequencer is written on each
// acknowledged read. All slots and the fill count clear when a new request
// starts.
// Assumes: slot_idx < MAX_DW whenever we is high.
module rrq_pack
    import rrq_pkg::*;
#(
    parameter int MAX_DW = 8,
    localparam int CNT_W = $clog2(MAX_DW + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       we,
    input  logic [CNT_W-1:0]           slot_idx,
    input  logic [WORD_W-1:0]          word,
    output logic [CNT_W-1:0]           filled,
    output logic [MAX_DW*WORD_W-1:0]   bytes_out
);

    localparam int BYTES_PER_DW = WORD_W / 8;

    // Purpose: count the dwords packed in the current request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            filled <= '0;
        end else if (we) begin
            filled <= filled + CNT_W'(1);
        end
    end

    for (genvar g = 0; g < MAX_DW; g++) begin : g_slot
        logic hit;
        assign hit = we && (slot_idx == CNT_W'(g));
        for (genvar j = 0; j < BYTES_PER_DW; j++) begin : g_byte
            logic [7:0] lane_q;
            // Purpose: store one byte lane of this slot.
            always_ff @(posedge clk) begin
                if (!rst_n || clear) begin
                    lane_q <= 8'h00;
                end else if (hit) begin
                    lane_q <= word[8*j +: 8];
                end
            end
            assign bytes_out[8*(g*BYTES_PER_DW + j) +: 8] = lane_q;
        end
    end

endmodule

// File: rtl/rrq_handler.sv
// Top: register read request handler. Collects a request frame, vets it
// (length before anything else), runs the register reads and packs the
// results into a byte array with a result code and a done pulse.
// Assumes: the register port answers every rd_req with rd_ack eventually.
module rrq_handler
    import rrq_pkg::*;
#(
    parameter int MAX_DW = 8,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(MAX_DW + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [31:0]              req_word,
    input  logic                     req_last,
    output logic                     req_ready,
    output logic                     rd_req,
    output logic [ADDR_W-1:0]        rd_addr,
    input  logic                     rd_ack,
    input  logic [31:0]              rd_data,
    output logic                     done,
    output logic [7:0]               result,
    output logic [CNT_W-1:0]         rsp_dwords,
    output logic [MAX_DW*32-1:0]     rsp_data
);

    frame_t           frm;
    logic             frm_vld;
    logic [7:0]       vet_code;
    logic             vet_go;
    logic             seq_idle;
    logic             start;
    logic             slot_we;
    logic [CNT_W-1:0] slot_idx;

    assign req_ready = seq_idle && !frm_vld;

    rrq_frame_rx u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (req_valid),
        .in_word  (req_word),
        .in_last  (req_last),
        .in_ready (req_ready),
        .frm_vld  (frm_vld),
        .frm      (frm)
    );

    rrq_vet #(.MAX_DW(MAX_DW)) u_vet (
        .frm  (frm),
        .code (vet_code),
        .go   (vet_go)
    );

    rrq_seq #(.MAX_DW(MAX_DW), .ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .frm_vld  (frm_vld),
        .frm      (frm),
        .vet_code (vet_code),
        .vet_go   (vet_go),
        .rd_ack   (rd_ack),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .idle     (seq_idle),
        .start    (start),
        .slot_we  (slot_we),
        .slot_idx (slot_idx),
        .done     (done),
        .result   (result)
    );

    rrq_pack #(.MAX_DW(MAX_DW)) u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (start),
        .we        (slot_we),
        .slot_idx  (slot_idx),
        .word      (rd_data),
        .filled    (rsp_dwords),
        .bytes_out (rsp_data)
    );

endmodule

// File: rtl/rrq_handler_chk.sv
// Checker: port-level properties of the read request handler. It keeps its
// own record of reads and acknowledges since the last frame end.
module rrq_handler_chk #(
    parameter int MAX_DW = 8,
    parameter int ADDR_W = 32,
    localparam int CNT_W = $clog2(MAX_DW + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              frm_vld,
    input logic              req_ready,
    input logic              rd_req,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              rd_ack,
    input logic              done,
    input logic [7:0]        result,
    input logic [CNT_W-1:0]  rsp_dwords
);

    logic          any_rd_q;
    logic [7:0]    acks_q;

    // Purpose: record reads and acknowledges since the last frame end.
    always_ff @(posedge clk) begin
        if (!rst_n || frm_vld) begin
            any_rd_q <= 1'b0;
            acks_q   <= '0;
        end else begin
            if (rd_req) any_rd_q <= 1'b1;
            if (rd_req && rd_ack) acks_q <= acks_q + 8'd1;
        end
    end

    // R2
    no_read_on_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result != 8'h00) |-> !any_rd_q);

    // R9
    ack_count_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == 8'h00) |-> (acks_q == 8'(rsp_dwords)));

    // R9
    done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6
    read_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (rd_addr[1:0] == 2'b00));

    // R6
    read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    // R6
    read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && rd_ack) |=> (!rd_req || rd_addr == $past(rd_addr) + ADDR_W'(4)));

    // R10
    busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req || done || frm_vld) |-> !req_ready);

    // R8
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(rsp_dwords) <= 32'(MAX_DW)));

endmodule

bind rrq_handler rrq_handler_chk #(.MAX_DW(MAX_DW), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_vld    (frm_vld),
    .req_ready  (req_ready),
    .rd_req     (rd_req),
    .rd_addr    (rd_addr),
    .rd_ack     (rd_ack),
    .done       (done),
    .result     (result),
    .rsp_dwords (rsp_dwords)
);

// File: tb/test_rrq_handler.sv
module test_rrq_handler;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_DW     = 8;
    localparam int ADDR_W     = 32;
    localparam int CNT_W      = $clog2(MAX_DW + 1);
    localparam int DBITS      = MAX_DW * 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [31:0]       req_word = '0;
    logic              req_last = 1'b0;
    logic              req_ready;
    logic              rd_req;
    logic [ADDR_W-1:0] rd_addr;
    logic              rd_ack = 1'b0;
    logic [31:0]       rd_data = '0;
    logic              done;
    logic [7:0]        result;
    logic [CNT_W-1:0]  rsp_dwords;
    logic [DBITS-1:0]  rsp_data;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [7:0]       res;
        int               dwords;
        logic [DBITS-1:0] data;
        int               nreads;
        string            tag;
    } exp_t;

    exp_t        sb[$];
    logic [31:0] exp_addr;
    int          seen_reads;

    rrq_handler #(.MAX_DW(MAX_DW), .ADDR_W(ADDR_W)) i_rrq_handler (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
        .req_last(req_last), .req_ready(req_ready), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .done(done),
        .result(result), .rsp_dwords(rsp_dwords), .rsp_data(rsp_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] reg_model(input logic [31:0] a);
        return {a[7:0] ^ 8'hA5, a[15:8], a[7:0] + 8'h3C, ~a[15:8]};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [DBITS-1:0] act, input logic [DBITS-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Register port model: random acknowledge delay, data from the address.
    always @(posedge clk) begin
        #2;
        if (rd_req && ($urandom % 3 != 0)) begin
            rd_ack  = 1'b1;
            rd_data = reg_model(rd_addr);
        end else begin
            rd_ack  = 1'b0;
            rd_data = 32'h0;
        end
    end

    // Monitor: follow read addresses and compare completions with the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rd_req && rd_ack) begin
                check(rd_addr == exp_addr, "R6", "read address",
                      DBITS'(rd_addr), DBITS'(exp_addr));
                exp_addr   = exp_addr + 32'd4;
                seen_reads = seen_reads + 1;
            end
            if (done) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R10", "done without a pending frame",
                          DBITS'(result), '0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(result == e.res, e.tag, "result code",
                          DBITS'(result), DBITS'(e.res));
                    check(int'(rsp_dwords) == e.dwords, "R9", "dword count",
                          DBITS'(rsp_dwords), DBITS'(e.dwords));
                    check(seen_reads == e.nreads, e.tag, "reads issued",
                          DBITS'(seen_reads), DBITS'(e.nreads));
                    check(rsp_data == e.data, "R7", "packed bytes (R8 unused zero)",
                          rsp_data, e.data);
                end
                seen_reads = 0;
            end
        end
    end

    task automatic run_case(input int nwords, input logic [31:0] addr,
                            input logic [31:0] cnt, input string tag_hint);
        exp_t e;
        e.data   = '0;
        e.dwords = 0;
        e.nreads = 0;
        if (nwords != 3) begin
            e.res = 8'h03; e.tag = "R2";
        end else if (addr[1:0] != 2'b00) begin
            e.res = 8'h04; e.tag = "R3";
        end else if (cnt == 0 || cnt > MAX_DW) begin
            e.res = 8'h05; e.tag = "R4";
        end else begin
            e.res = 8'h00; e.tag = "R9";
            e.dwords = int'(cnt);
            e.nreads = int'(cnt);
            for (int k = 0; k < int'(cnt); k++) begin
                e.data[32*k +: 32] = reg_model(addr + 32'(4*k));
            end
        end
        if (tag_hint != "") e.tag = tag_hint;
        exp_addr   = addr;
        seen_reads = 0;
        sb.push_back(e);
        for (int k = 0; k < nwords; k++) begin
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            req_valid = 1'b1;
            req_word  = (k == 1) ? addr : (k == 2) ? cnt : (32'hDEAD0000 | 32'(k));
            req_last  = (k == nwords - 1);
        end
        // Keep offering junk words while busy; they must be ignored (R10).
        @(negedge clk);
        req_word = 32'hBADF00D4;
        req_last = 1'b1;
        check(req_ready == 1'b0, "R10", "ready after last word",
              DBITS'(req_ready), '0);
        while (!done) @(negedge clk);
        req_valid = 1'b0;
        req_last  = 1'b0;
        @(negedge clk);
        check(sb.size() == 0, "R9", "completion consumed", DBITS'(sb.size()), '0);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        check(1'b0, "R9", "watchdog expired", '0, '1);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        seen_reads = 0;
        exp_addr   = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check(req_ready == 1'b1, "R1", "req_ready", DBITS'(req_ready), 1);
        check(done == 1'b0, "R1", "done", DBITS'(done), 0);
        check(rd_req == 1'b0, "R1", "rd_req", DBITS'(rd_req), 0);
        check(result == 8'h00, "R1", "result", DBITS'(result), 0);
        check(rsp_dwords == '0, "R1", "rsp_dwords", DBITS'(rsp_dwords), 0);
        check(rsp_data == '0, "R1", "rsp_data", rsp_data, '0);

        // R9, R7: successful runs of several lengths, including the maximum
        run_case(3, 32'h0000_0100, 32'd2, "");
        run_case(3, 32'h0000_1230, 32'd1, "");
        run_case(3, 32'h0000_4000, 32'd8, "");
        // R8: shorter run after the full one leaves upper slots zero
        run_case(3, 32'h0000_0080, 32'd3, "R8");
        // R6: address wraps at the top of the space
        run_case(3, 32'hFFFF_FFF8, 32'd3, "R6");
        // R2: wrong lengths, short and long, with otherwise valid fields
        run_case(2, 32'h0000_0100, 32'd2, "");
        run_case(1, 32'h0000_0100, 32'd2, "");
        run_case(4, 32'h0000_0100, 32'd2, "");
        run_case(9, 32'h0000_0100, 32'd2, "");
        // R3: unaligned start addresses
        run_case(3, 32'h0000_0102, 32'd2, "");
        run_case(3, 32'h0000_0001, 32'd1, "");
        // R4: count out of range
        run_case(3, 32'h0000_0200, 32'd0, "");
        run_case(3, 32'h0000_0200, 32'd9, "");
        run_case(3, 32'h0000_0200, 32'h1000_0001, "");
        // R5: priority when several checks fail
        run_case(4, 32'h0000_0203, 32'd0, "R5");
        run_case(3, 32'h0000_0203, 32'd0, "R5");
        // back to a good request after errors
        run_case(3, 32'h0000_0010, 32'd4, "");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule